// File: doc/BRIEF.md
# Looping I2C transaction sequencer

This block runs a list of I2C transactions on one bus channel without host help once the list is in place. The host fills a slave table, a byte-count table, a transaction count and a shared byte buffer through a small register port. After a start command, or after a trigger edge when trigger pacing is on, the block walks the list and drives a byte-level bus engine one command at a time. Each transaction sends a START, then the address byte, then its data bytes. A STOP closes every pass through the list. Bytes read from slaves are written back into buffer slots that the host reserved beforehand.

The whole list repeats for a programmed number of passes. Each transaction keeps a small status code that the host can read. Sticky flags report the end of the loop, a stop on request, a slave NACK, a missed frame deadline and buffer misuse. The interrupt output is the OR of all the flags. The bit-level SCL/SDA engine is outside this block. It talks to the block through a command/response port: the block holds a command valid until the engine returns `eng_done` for one cycle.

Top module: `i2c_seq_loop`

## Requirements
- R1: The register at address 3 writes byte-count entries and the register at address 4 writes slave entries, each through its own hidden pointer that advances by one. Slave entry bit 0 set to 1 marks a read. Writing CTRL (address 0) with bit 2 set puts both pointers and the data pointer back to zero and clears the buffer extent. The extent is the sum of the counts written since then. The transaction count lives at address 2.
- R2: The buffer-error flag (FLAGS bit 4) is set, and the access does nothing else, in these cases: a DATA (address 5) access at a pointer at or past the extent, a DPTR (address 7) write at or past the extent, or a table write past its capacity. All flags stay set until the host writes 1 to their bit at address 1.
- R3: When a pass begins, the status of transaction 0 becomes 2 (active), the other configured transactions read 1 (queued) and unused slots read 0. The status is read at address 9 for the index written at address 8.
- R4: For each transaction the engine receives command 1 (START), then command 2 (address) carrying the slave entry, then one command per byte: 3 (write, carrying the buffer byte) or 4 (read). After the last transaction comes command 5 (STOP). Read bytes are stored in their buffer slots in order, and a finished transaction reads status 3.
- R5: The list runs as many passes as the frame count at address 6 (0 counts as 1). After the last STOP, FLAGS bit 0 is set and the channel goes idle (CTRL read bit 0 = 0).
- R6: A NACK on a write data byte sets that transaction's status to 5 and sets FLAGS bit 2. A STOP follows, and then the channel goes idle without setting bit 0.
- R7: A NACK on the address byte sets that transaction's status to 4 and sets FLAGS bit 2. A STOP follows, the channel goes idle, and later transactions stay at 1.
- R8: A CTRL write with bit 1 set while the channel is active makes it idle on the next cycle and sets FLAGS bits 1 and 0.
- R9: With CTRL bit 3 (trigger mode) set at start, each pass waits for a trigger edge. CTRL bit 4 = 0 selects the rising edge and 1 selects the falling edge. Edges of the other direction do nothing.
- R10: While the channel is active, writes to CTRL bits 3 and 4 have no effect.
- R11: In trigger mode, a selected edge that arrives while a pass is still running sets FLAGS bit 3.
- R12: While the sequencer owns the buffer for a data byte (`host_busy` = 1), host DATA accesses are ignored and the data pointer holds.
- R13: `irq` is high exactly when any FLAGS bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (advances the data pointer) |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| host_busy | output | 1 | Sequencer holds the buffer; DATA accesses are ignored |
| trig | input | 1 | External frame trigger |
| irq | output | 1 | Interrupt, OR of the sticky flags |
| eng_cmd_valid | output | 1 | Command to the byte engine is pending |
| eng_cmd | output | 3 | Command code: 1 START, 2 address, 3 write, 4 read, 5 STOP |
| eng_wdata | output | 8 | Address or data byte for the command |
| eng_done | input | 1 | Engine finished the pending command |
| eng_ack | input | 1 | Slave acknowledged the address or written byte |
| eng_rdata | input | 8 | Byte received on a read command |

## Verification
Assertions check on every cycle that the flags stay sticky, that the trigger settings stay frozen while the channel runs, and that the data pointer holds while a DATA access is blocked. They also check that a stop request forces the idle state with both flags set, and that the loop-done flag only rises when the channel is idle. Other behaviour depends on a whole exchange with the engine and is shown only by the bench scenarios. This covers the exact command stream over two passes, the read data landing in reserved slots, the status codes after each kind of NACK, edge pacing with both polarities, and the frame error caused by an early edge.

// File: rtl/i2c_seq_loop.sv
module i2c_seq_loop #(
  parameter int NTRANS    = 64,
  parameter int BUF_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_busy,
  input  logic       trig,
  output logic       irq,
  output logic       eng_cmd_valid,
  output logic [2:0] eng_cmd,
  output logic [7:0] eng_wdata,
  input  logic       eng_done,
  input  logic       eng_ack,
  input  logic [7:0] eng_rdata
);
  localparam int TW = $clog2(NTRANS);
  localparam int BW = $clog2(BUF_BYTES);
  localparam int EW = BW + 1;
  localparam logic [3:0] A_CTRL = 4'd0, A_FLAGS = 4'd1, A_TCNT = 4'd2, A_LEN = 4'd3, A_SLA = 4'd4,
                         A_DATA = 4'd5, A_FRM = 4'd6, A_DPTR = 4'd7, A_SSEL = 4'd8, A_STAT = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_ADDR, S_DATA, S_STOP} st_t;
  st_t state;

  logic [TW:0]   tcount, lptr, sptr, tidx;
  logic [EW-1:0] extent;
  logic [BW-1:0] dptr, bptr, buf_addr;
  logic [7:0]    frames, frame_cnt, bcnt, buf_q, cur_sla, cur_len;
  logic [TW-1:0] ssel;
  logic [4:0]    flags, flag_set, flag_clr;
  logic          trig_en, trig_pol, trig_q, abort;
  logic [7:0]    len_t [NTRANS];
  logic [7:0]    sla_t [NTRANS];
  logic [2:0]    stat  [NTRANS];
  logic [7:0]    mem   [BUF_BYTES];

  logic active, wr_ctrl, dptr_ok, len_ok, sla_ok, dptr_wr_ok, data_acc, hdata_we, len_we, sla_we;
  logic is_rd, seq_we, trig_edge, last_trans, frame_last, go, stopseq, new_frame, trans_end;

  assign active     = state != S_IDLE;
  assign host_busy  = state == S_DATA;
  assign irq        = |flags;
  assign wr_ctrl    = host_we && host_addr == A_CTRL;
  assign dptr_ok    = {1'b0, dptr} < extent;
  assign len_ok     = lptr < (TW+1)'(NTRANS) &&
                      ({1'b0, extent} + (EW+1)'(host_wdata)) <= (EW+1)'(BUF_BYTES);
  assign sla_ok     = sptr < (TW+1)'(NTRANS);
  assign dptr_wr_ok = EW'(host_wdata) < extent;
  assign data_acc   = (host_we || host_re) && host_addr == A_DATA && !host_busy;
  assign hdata_we   = host_we && host_addr == A_DATA && !host_busy && dptr_ok;
  assign len_we     = host_we && host_addr == A_LEN && len_ok;
  assign sla_we     = host_we && host_addr == A_SLA && sla_ok;
  assign buf_addr   = host_busy ? bptr : dptr;
  assign buf_q      = mem[buf_addr];
  assign cur_sla    = sla_t[tidx[TW-1:0]];
  assign cur_len    = len_t[tidx[TW-1:0]];
  assign is_rd      = cur_sla[0];
  assign seq_we     = state == S_DATA && eng_done && is_rd;
  assign trig_edge  = trig_pol ? (trig_q & ~trig) : (~trig_q & trig);
  assign last_trans = (tidx + 1'b1) == tcount;
  assign frame_last = (frame_cnt + 8'd1) >= frames;
  assign go         = wr_ctrl && host_wdata[0] && state == S_IDLE && tcount != '0;
  assign stopseq    = wr_ctrl && host_wdata[1] && active;
  assign new_frame  = (go && !host_wdata[3]) || (state == S_WAIT && trig_edge) ||
                      (state == S_STOP && eng_done && !abort && !frame_last && !trig_en);
  assign trans_end  = eng_done && ((state == S_ADDR && eng_ack && cur_len == 8'd0) ||
                      (state == S_DATA && (is_rd || eng_ack) && (bcnt + 8'd1) == cur_len));

  assign eng_cmd_valid = state inside {S_START, S_ADDR, S_DATA, S_STOP};
  assign eng_wdata     = (state == S_ADDR) ? cur_sla : buf_q;
  always_comb begin
    case (state)
      S_START: eng_cmd = 3'd1;
      S_ADDR:  eng_cmd = 3'd2;
      S_DATA:  eng_cmd = is_rd ? 3'd4 : 3'd3;
      S_STOP:  eng_cmd = 3'd5;
      default: eng_cmd = 3'd0;
    endcase
  end

  always_comb begin
    flag_clr = (host_we && host_addr == A_FLAGS) ? host_wdata[4:0] : 5'd0;
    flag_set[4] = (host_we && host_addr == A_LEN && !len_ok) || (host_we && host_addr == A_SLA && !sla_ok) ||
                  (data_acc && !dptr_ok) || (host_we && host_addr == A_DPTR && !dptr_wr_ok);
    flag_set[3] = trig_en && trig_edge && active && state != S_WAIT;
    flag_set[2] = eng_done && !eng_ack && (state == S_ADDR || (state == S_DATA && !is_rd));
    flag_set[1] = stopseq;
    flag_set[0] = stopseq || (state == S_STOP && eng_done && !abort && frame_last);
  end

  always_comb begin
    case (host_addr)
      A_CTRL:  host_rdata = {3'b0, trig_pol, trig_en, 2'b0, active};
      A_FLAGS: host_rdata = {3'b0, flags};
      A_TCNT:  host_rdata = 8'(tcount);
      A_DATA:  host_rdata = buf_q;
      A_FRM:   host_rdata = frames;
      A_DPTR:  host_rdata = 8'(dptr);
      A_SSEL:  host_rdata = 8'(ssel);
      A_STAT:  host_rdata = {5'b0, stat[ssel]};
      default: host_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (seq_we) mem[bptr] <= eng_rdata;
    else if (hdata_we) mem[dptr] <= host_wdata;
    if (len_we) len_t[lptr[TW-1:0]] <= host_wdata;
    if (sla_we) sla_t[sptr[TW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tcount <= '0; lptr <= '0; sptr <= '0; tidx <= '0; extent <= '0;
      dptr <= '0; bptr <= '0; frames <= 8'd1; frame_cnt <= '0; bcnt <= '0; ssel <= '0;
      flags <= '0; trig_en <= 1'b0; trig_pol <= 1'b0; trig_q <= 1'b0; abort <= 1'b0;
      for (int i = 0; i < NTRANS; i++) stat[i] <= 3'd0;
    end else begin
      trig_q <= trig;
      flags  <= (flags & ~flag_clr) | flag_set;
      if (wr_ctrl) begin
        if (!active) begin trig_en <= host_wdata[3]; trig_pol <= host_wdata[4]; end
        if (host_wdata[2]) begin lptr <= '0; sptr <= '0; dptr <= '0; extent <= '0; end
      end
      if (host_we && host_addr == A_TCNT && !active)
        tcount <= (host_wdata > 8'(NTRANS)) ? (TW+1)'(NTRANS) : (TW+1)'(host_wdata);
      if (host_we && host_addr == A_FRM) frames <= host_wdata;
      if (host_we && host_addr == A_SSEL) ssel <= TW'(host_wdata);
      if (len_we) begin lptr <= lptr + 1'b1; extent <= extent + EW'(host_wdata); end
      if (sla_we) sptr <= sptr + 1'b1;
      if (data_acc && dptr_ok) dptr <= dptr + 1'b1;
      if (host_we && host_addr == A_DPTR && dptr_wr_ok) dptr <= BW'(host_wdata);

      case (state)
        S_IDLE:  if (go) begin frame_cnt <= '0; state <= host_wdata[3] ? S_WAIT : S_START; end
        S_WAIT:  if (trig_edge) state <= S_START;
        S_START: if (eng_done) state <= S_ADDR;
        S_ADDR:  if (eng_done) begin
                   if (!eng_ack) begin stat[tidx[TW-1:0]] <= 3'd4; abort <= 1'b1; state <= S_STOP; end
                   else if (cur_len != 8'd0) state <= S_DATA;
                 end
        S_DATA:  if (eng_done) begin
                   if (!is_rd && !eng_ack) begin stat[tidx[TW-1:0]] <= 3'd5; abort <= 1'b1; state <= S_STOP; end
                   else begin bptr <= bptr + 1'b1; bcnt <= bcnt + 8'd1; end
                 end
        S_STOP:  if (eng_done) begin
                   if (abort || frame_last) state <= S_IDLE;
                   else begin frame_cnt <= frame_cnt + 8'd1; state <= trig_en ? S_WAIT : S_START; end
                 end
        default: state <= S_IDLE;
      endcase
      if (trans_end) begin
        stat[tidx[TW-1:0]] <= 3'd3;
        bcnt <= 8'd0;
        if (last_trans) state <= S_STOP;
        else begin
          tidx <= tidx + 1'b1;
          stat[tidx[TW-1:0] + 1'b1] <= 3'd2;
          state <= S_START;
        end
      end
      if (new_frame) begin
        tidx <= '0; bptr <= '0; bcnt <= '0; abort <= 1'b0;
        for (int i = 0; i < NTRANS; i++)
          stat[i] <= (i == 0) ? 3'd2 : (((TW+1)'(i) < tcount) ? 3'd1 : 3'd0);
      end
      if (stopseq) state <= S_IDLE;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == A_FLAGS) |=> ((flags & $past(flags)) == $past(flags))); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> !active); // R5
  AST_STOPSEQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_ctrl && host_wdata[1]) |=> (!active && flags[1:0] == 2'b11)); // R8
  AST_TRIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(trig_pol) && $stable(trig_en))); // R10
  AST_BUSY_NO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && (host_we || host_re) && host_addr == A_DATA) |=> $stable(dptr)); // R12
endmodule

// File: tb/tb_i2c_seq_loop.sv
module tb_i2c_seq_loop;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0, host_re = 0, trig = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0, eng_rdata = 0;
  logic eng_done = 0, eng_ack = 1;
  logic [7:0] host_rdata, eng_wdata;
  logic host_busy, irq, eng_cmd_valid;
  logic [2:0] eng_cmd;

  i2c_seq_loop dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, nlog = 0, hold_at = 1000, rdcount = 0;
  int nack_t = -1, nack_b = -1, ti = -1, bi = 0;
  logic [2:0] log_cmd [64];
  logic [7:0] log_dat [64];
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1 host_re = 0;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  task automatic stat_chk(string req, int idx, int e);
    wr(4'd8, 8'(idx));
    rdchk(req, 4'd9, 8'(e));
  endtask

  // behavioural byte engine
  initial begin
    forever begin
      @(negedge clk);
      eng_done = 0;
      if (eng_cmd_valid && nlog < hold_at) begin
        @(negedge clk);
        if (eng_cmd_valid && nlog < hold_at) begin
          eng_ack = 1;
          case (eng_cmd)
            3'd1: begin ti++; bi = 0; end
            3'd2: begin eng_ack = !(ti == nack_t && nack_b == 0); bi = 1; end
            3'd3: begin eng_ack = !(ti == nack_t && bi == nack_b); bi++; end
            3'd4: begin eng_rdata = 8'hC0 + 8'(rdcount); rdcount++; bi++; end
            3'd5: ti = -1;
            default: ;
          endcase
          if (nlog < 64) begin
            log_cmd[nlog] = eng_cmd;
            log_dat[nlog] = (eng_cmd == 3'd4) ? eng_rdata : eng_wdata;
          end
          nlog++;
          eng_done = 1;
        end
      end
    end
  end

  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    16'h0004, 16'h0202, 16'h0302, 16'h0301, 16'h0450, 16'h04A1, 16'h0511, 16'h0522,
    16'h05FF, 16'h1100, 16'h0577, 16'h1110, 16'h0110, 16'h1100, 16'h0701, 16'h1522,
    16'h1702, 16'h0705, 16'h1110, 16'h011F, 16'h1202, 16'h1000};

  localparam logic [2:0] EXP_CMD [8] = '{3'd1, 3'd2, 3'd3, 3'd3, 3'd1, 3'd2, 3'd4, 3'd5};
  localparam logic [7:0] EXP_DAT [8] = '{8'h00, 8'h50, 8'h11, 8'h22, 8'h00, 8'hA1, 8'h00, 8'h00};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0, errs;
    repeat (3) @(posedge clk);
    #1 chk("R13 reset irq", irq, 0);
    chk("R12 reset busy", host_busy, 0);
    rst_n = 1;
    rdchk("R5 reset idle", 4'd0, 8'h00);
    rdchk("R2 reset flags", 4'd1, 8'h00);

    // R1/R2 table and buffer vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15:12] == 4'h0) wr(VEC[i][11:8], VEC[i][7:0]);
      else rdchk($sformatf("R1/R2 vector %0d", i), VEC[i][11:8], VEC[i][7:0]);
    end

    // R3 R4 R5 two passes
    wr(4'd6, 8'd2);
    hold_at = 0;
    wr(4'd0, 8'h01);
    stat_chk("R3 first active", 0, 2);
    stat_chk("R3 second queued", 1, 1);
    stat_chk("R3 unused idle", 2, 0);
    rdchk("R5 active", 4'd0, 8'h01);
    n0 = nlog;
    hold_at = 1000;
    while (!irq) @(posedge clk);
    chk("R5 command count", nlog - n0, 16);
    errs = 0;
    for (int k = 0; k < 16; k++) begin
      if (log_cmd[n0 + k] !== EXP_CMD[k % 8]) errs++;
      if ((EXP_CMD[k % 8] inside {3'd2, 3'd3}) && log_dat[n0 + k] !== EXP_DAT[k % 8]) errs++;
    end
    chk("R4 command stream mismatches", errs, 0);
    rdchk("R5 loop done flag", 4'd1, 8'h01);
    rdchk("R5 idle after loop", 4'd0, 8'h00);
    chk("R13 irq with flag", irq, 1);
    stat_chk("R4 status done 0", 0, 3);
    stat_chk("R4 status done 1", 1, 3);
    wr(4'd7, 8'd2);
    rdchk("R4 read byte stored", 4'd5, 8'hC1);
    wr(4'd1, 8'h1F);
    #1 chk("R13 irq cleared", irq, 0);

    // R6 data NACK
    wr(4'd6, 8'd1);
    nack_t = 0; nack_b = 2;
    n0 = nlog;
    wr(4'd0, 8'h01);
    while (!irq) @(posedge clk);
    repeat (4) @(posedge clk);
    rdchk("R6 nack flag only", 4'd1, 8'h04);
    stat_chk("R6 data nack status", 0, 5);
    stat_chk("R6 later queued", 1, 1);
    chk("R6 commands", nlog - n0, 5);
    chk("R6 ends with stop", log_cmd[nlog - 1], 5);
    rdchk("R6 idle", 4'd0, 8'h00);
    wr(4'd1, 8'h1F);

    // R7 address NACK
    nack_t = 1; nack_b = 0;
    n0 = nlog;
    wr(4'd0, 8'h01);
    while (!irq) @(posedge clk);
    repeat (4) @(posedge clk);
    rdchk("R7 nack flag", 4'd1, 8'h04);
    stat_chk("R7 first done", 0, 3);
    stat_chk("R7 address nack status", 1, 4);
    chk("R7 ends with stop", log_cmd[nlog - 1], 5);
    wr(4'd1, 8'h1F);
    nack_t = -1; nack_b = -1;

    // R8 stop request while looping
    wr(4'd6, 8'd200);
    wr(4'd0, 8'h01);
    repeat (30) @(posedge clk);
    wr(4'd0, 8'h02);
    rdchk("R8 idle after stop", 4'd0, 8'h00);
    rdchk("R8 stopped and done flags", 4'd1, 8'h03);
    wr(4'd1, 8'h1F);

    // R9 R10 R11 R12 trigger pacing
    wr(4'd6, 8'd2);
    wr(4'd0, 8'h09);
    n0 = nlog;
    repeat (10) @(posedge clk);
    chk("R9 waits for edge", nlog - n0, 0);
    rdchk("R9 armed", 4'd0, 8'h09);
    wr(4'd0, 8'h10);
    rdchk("R10 settings frozen", 4'd0, 8'h09);
    hold_at = n0 + 3;
    @(negedge clk); trig = 1;
    repeat (20) @(posedge clk);
    #1 chk("R12 busy during byte", host_busy, 1);
    wr(4'd7, 8'd0);
    wr(4'd5, 8'h77);
    @(negedge clk); trig = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); trig = 1;
    repeat (2) @(posedge clk);
    rdchk("R11 frame error", 4'd1, 8'h08);
    hold_at = 1000;
    repeat (60) @(posedge clk);
    chk("R9 one pass per edge", nlog - n0, 8);
    @(negedge clk); trig = 0;
    repeat (20) @(posedge clk);
    chk("R9 wrong edge ignored", nlog - n0, 8);
    @(negedge clk); trig = 1;
    repeat (80) @(posedge clk);
    chk("R9 second pass", nlog - n0, 16);
    rdchk("R11 flags after loop", 4'd1, 8'h09);
    rdchk("R9 idle keeps mode", 4'd0, 8'h08);
    wr(4'd7, 8'd0);
    rdchk("R12 blocked write ignored", 4'd5, 8'h11);
    wr(4'd1, 8'h1F);

    // R9 falling edge
    wr(4'd6, 8'd1);
    wr(4'd0, 8'h19);
    n0 = nlog;
    repeat (10) @(posedge clk);
    chk("R9 falling mode waits", nlog - n0, 0);
    @(negedge clk); trig = 0;
    repeat (80) @(posedge clk);
    chk("R9 falling edge pass", nlog - n0, 8);
    rdchk("R9 falling done", 4'd1, 8'h01);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule